// File: doc/BRIEF.md
# Microcode Sequencer With Hardware Loops

The sequencer runs a short program held in a 32-word internal store. The program is loaded through a write port while the block is idle. A start pulse then begins execution at address 0, and the sequencer executes one instruction per clock. Each output instruction places its 8-bit payload on a stream as a one-cycle valid strobe. A stop mark on an instruction ends the run: busy falls and done pulses.

Two set-address instructions load two shared branch registers. A loop instruction sends execution back to the lower of those two addresses. It does this until its routine has run the number of times given in its count field, and then it falls through. A select bit picks one of two independent repetition counters, so one loop can sit inside another. The branch registers are not saved per counter, so the program must reload them after an inner loop and before the outer loop instruction is reached.

Top module: `mseq_top`

## Requirements
- R1: While reset is held and straight after it, busy_o, done_o and valid_o are low.
- R2: A start_i pulse sampled while idle begins execution at address 0, and busy_o is high from the next cycle. A start_i pulse sampled while busy has no effect on the run.
- R3: Bits 20:18 of each word are the opcode. The sequencer executes one instruction per clock. Opcode 0 drives valid_o high for one cycle with bits 7:0 on payload_o, in the cycle after the edge that executes it. No other opcode produces an output, and opcodes 4 to 7 act as no-ops.
- R4: Opcode 1 loads branch register A from bits 4:0, and opcode 2 loads branch register B from bits 4:0. A start clears both registers to 0.
- R5: Opcode 3 is the loop instruction. When it repeats, it branches to the lower of A and B. When the repetitions are done, execution continues at the next address.
- R6: Bits 15:8 of the loop instruction give the total number of runs of its routine. A value of 0 or 1 runs the routine once.
- R7: Bit 16 of the loop instruction selects counter 0 or counter 1. The two counters are independent, so an inner loop on one counter runs completely on every pass of an outer loop on the other. A counter is back at idle once its loop exits.
- R8: Both loops read the same branch registers at the time the loop instruction executes. A value written by an inner loop's setup stays in force for the outer loop.
- R9: Bit 17 (stop) on any non-loop instruction lets that instruction complete. In the next cycle busy_o is low and done_o is high for exactly one cycle. A run of T executed instructions therefore shows done_o T cycles after start_i is sampled. The stop bit on a loop instruction is ignored.
- R10: A program write (prog_we_i, prog_addr_i, prog_data_i) takes effect only while idle. A write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program store write enable |
| prog_addr_i | input | 5 | Program store write address |
| prog_data_i | input | 21 | Instruction word to write |
| start_i | input | 1 | Begin execution at address 0 |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle pulse when a run ends |
| valid_o | output | 1 | Output strobe |
| payload_o | output | 8 | Payload of the output instruction |

## Verification
A wrong counter value or a wrong branch target changes how many payloads the run produces and how long it takes. The error shows at the ports within one loop pass, as a missing or extra payload or as done arriving early or late. A wrong branch register value lands execution on a different instruction, and the emitted payload sequence shows this at once. The bench sweeps loop counts, counter choice and the order of the branch addresses. For each case it predicts the payload sequence and the exact cycle of the done pulse.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CNT_W     = 8;
  localparam int ARG_W     = 8;
  localparam int NUM_LOOPS = 2;

  typedef enum logic [2:0] {
    OP_EMIT = 3'd0,
    OP_SETA = 3'd1,
    OP_SETB = 3'd2,
    OP_LOOP = 3'd3
  } op_e;

  typedef struct packed {
    logic [2:0]       op;
    logic             stop;
    logic             sel;
    logic [CNT_W-1:0] cnt;
    logic [ARG_W-1:0] arg;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/mseq_prog_mem.sv
module mseq_prog_mem #(
  parameter int DEPTH = 32,
  parameter int W     = 21,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mseq_loop_ctr.sv
module mseq_loop_ctr #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          hit_i,
  input  logic [CW-1:0] count_i,
  output logic          taken_o
);
  logic [CW-1:0] cnt_q;
  logic          idle;

  assign idle = (cnt_q == '0);

  // idle: start a new loop if more than one run requested; else step down
  always_comb taken_o = hit_i && (idle ? (count_i > CW'(1)) : (cnt_q != CW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (hit_i) begin
      if (idle) cnt_q <= (count_i > CW'(1)) ? count_i - CW'(1) : '0;
      else      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [PC_W-1:0]    prog_addr_i,
  input  logic [INSTR_W-1:0] prog_data_i,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               valid_o,
  output logic [ARG_W-1:0]   payload_o
);
  logic               run_q, done_q, valid_q;
  logic [ARG_W-1:0]   payload_q;
  logic [PC_W-1:0]    pc_q, bra_q, brb_q, target;
  logic [INSTR_W-1:0] rdata;
  instr_t             instr;
  logic               start_go, is_loop, is_emit, halt, taken;
  logic [NUM_LOOPS-1:0] taken_vec;

  mseq_prog_mem #(.DEPTH(DEPTH), .W(INSTR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i && !run_q),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc_q),
    .rdata_o (rdata)
  );

  assign instr    = instr_t'(rdata);
  assign start_go = start_i && !run_q;
  assign is_loop  = run_q && (instr.op == OP_LOOP);
  assign is_emit  = run_q && (instr.op == OP_EMIT);
  assign halt     = run_q && instr.stop && (instr.op != OP_LOOP);
  assign target   = (bra_q < brb_q) ? bra_q : brb_q;

  for (genvar gi = 0; gi < NUM_LOOPS; gi++) begin : g_loop
    mseq_loop_ctr #(.CW(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_go),
      .hit_i   (is_loop && (instr.sel == gi[0])),
      .count_i (instr.cnt),
      .taken_o (taken_vec[gi])
    );
  end

  assign taken = |taken_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      done_q    <= 1'b0;
      valid_q   <= 1'b0;
      payload_q <= '0;
      pc_q      <= '0;
      bra_q     <= '0;
      brb_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= is_emit;
      if (is_emit) payload_q <= instr.arg;
      if (start_go) begin
        run_q <= 1'b1;
        pc_q  <= '0;
        bra_q <= '0;
        brb_q <= '0;
      end else if (run_q) begin
        pc_q <= taken ? target : pc_q + PC_W'(1);
        if (instr.op == OP_SETA) bra_q <= instr.arg[PC_W-1:0];
        if (instr.op == OP_SETB) brb_q <= instr.arg[PC_W-1:0];
        if (halt) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = run_q;
  assign done_o    = done_q;
  assign valid_o   = valid_q;
  assign payload_o = payload_q;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic valid_o
);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !valid_o);

  // R3
  valid_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (busy_o || done_o));
endmodule

bind mseq_top mseq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .valid_o (valid_o)
);

// File: tb/mseq_top_tb_top.sv
module mseq_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        prog_we_i = 1'b0, start_i = 1'b0;
  logic [4:0]  prog_addr_i = '0;
  logic [20:0] prog_data_i = '0;
  logic        busy_o, done_o, valid_o;
  logic [7:0]  payload_o;

  mseq_top dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got [1024];
  int gcyc [1024];
  int n_got, cyc;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [20:0] enc(int op, bit stp, bit sel, int cnt, int arg);
    return {3'(op), stp, sel, 8'(cnt), 8'(arg)};
  endfunction

  task automatic wr(int a, logic [20:0] d);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = 5'(a); prog_data_i = d;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  // poke > 0: pulse start and write addr 2 at that cycle of the run
  task automatic run(int poke);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    n_got = 0; cyc = 0;
    chk("R2", "busy after start", int'(busy_o), 1);
    forever begin
      @(negedge clk_i);
      cyc++;
      if (valid_o && n_got < 1024) begin got[n_got] = payload_o; gcyc[n_got] = cyc; n_got++; end
      if (done_o) break;
      if (cyc > 5000) begin chk("R9", "run watchdog", 0, 1); break; end
      if (poke == cyc) begin
        start_i = 1'b1; prog_we_i = 1'b1; prog_addr_i = 5'd2;
        prog_data_i = enc(0, 1, 0, 0, 8'h99);
      end else begin
        start_i = 1'b0; prog_we_i = 1'b0;
      end
    end
    start_i = 1'b0; prog_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog global actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nv [7] = '{0, 1, 2, 3, 7, 42, 255};
    // R1 reset state
    #(CLK_P * 2);
    chk("R1", "busy in reset", int'(busy_o), 0);
    chk("R1", "done in reset", int'(done_o), 0);
    chk("R1", "valid in reset", int'(valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy after reset", int'(busy_o), 0);

    // R3 straight line, no-op opcode
    wr(0, enc(0, 0, 0, 0, 8'h11));
    wr(1, enc(0, 0, 0, 0, 8'h22));
    wr(2, enc(5, 0, 0, 0, 8'h44));
    wr(3, enc(0, 1, 0, 0, 8'h33));
    run(0);
    chk("R3", "straight count", n_got, 3);
    chk("R3", "first payload", int'(got[0]), 'h11);
    chk("R3", "first cycle", gcyc[0], 1);
    chk("R3", "third payload after no-op", int'(got[2]), 'h33);
    chk("R3", "third cycle", gcyc[2], 4);
    chk("R9", "done cycle", cyc, 4);
    @(negedge clk_i);
    chk("R9", "done one cycle", int'(done_o), 0);
    chk("R9", "busy low after stop", int'(busy_o), 0);

    // R4 R5 R6 R7 R9 loop count sweep
    for (int i = 0; i < 7; i++) begin
      int n = nv[i];
      int runs = (n < 2) ? 1 : n;
      int bad = 0;
      wr(0, enc(1, 0, 0, 0, (i % 2) ? 4 : 2));
      wr(1, enc(2, 0, 0, 0, (i % 2) ? 2 : 4));
      wr(2, enc(0, 0, 0, 0, 8'h23));
      wr(3, enc(3, i % 2, i % 2, n, 0));
      wr(4, enc(0, 1, 0, 0, 8'hEE));
      run(0);
      chk("R6", "runs of routine", n_got, runs + 1);
      for (int k = 0; k < runs && k < n_got; k++) if (got[k] != 8'h23) bad++;
      chk("R4", "loop body payloads (lower address)", bad, 0);
      chk("R5", "fall-through payload", int'(got[n_got-1]), 'hEE);
      chk("R9", "loop cycles, stop on loop ignored", cyc, 2 + 2 * runs + 1);
    end

    // R7 nested loops, K outer M inner, with mid-run poke (R2, R10)
    wr(0, enc(1, 0, 0, 0, 2));
    wr(1, enc(2, 0, 0, 0, 2));
    wr(2, enc(0, 0, 0, 0, 8'hA0));
    wr(3, enc(1, 0, 0, 0, 5));
    wr(4, enc(2, 0, 0, 0, 5));
    wr(5, enc(0, 0, 0, 0, 8'hB0));
    wr(6, enc(3, 0, 1, 4, 0));
    wr(7, enc(1, 0, 0, 0, 2));
    wr(8, enc(2, 0, 0, 0, 2));
    wr(9, enc(3, 0, 0, 3, 0));
    wr(10, enc(0, 1, 0, 0, 8'hFF));
    for (int pass = 0; pass < 2; pass++) begin
      int bad = 0;
      run(pass == 0 ? 10 : 0);
      chk("R7", "nested count", n_got, 3 * 5 + 1);
      for (int k = 0; k < 15 && k < n_got; k++)
        if (got[k] != ((k % 5 == 0) ? 8'hA0 : 8'hB0)) bad++;
      chk("R7", "nested order", bad, 0);
      chk("R7", "nested cycles", cyc, 2 + 3 * (6 + 2 * 4) + 1);
      if (pass == 0) chk("R2", "start while busy ignored, done", int'(got[15]), 'hFF);
      else chk("R10", "write while busy ignored", int'(got[0]), 'hA0);
    end

    // R8 branch registers not restored before the outer loop
    wr(7, enc(4, 0, 0, 0, 0));
    wr(8, enc(4, 0, 0, 0, 0));
    wr(6, enc(3, 0, 1, 2, 0));
    wr(9, enc(3, 0, 0, 2, 0));
    run(0);
    chk("R8", "shared regs count", n_got, 6);
    chk("R8", "single outer head", int'(got[0]), 'hA0);
    chk("R8", "outer returns to inner start", int'(got[3]), 'hB0);
    chk("R8", "shared regs cycles", cyc, 20);

    // R9 stop on a set-address instruction
    wr(0, enc(0, 0, 0, 0, 8'h5A));
    wr(1, enc(1, 1, 0, 0, 3));
    wr(2, enc(0, 1, 0, 0, 8'h77));
    run(0);
    chk("R9", "stop on set-address count", n_got, 1);
    chk("R9", "stop on set-address cycles", cyc, 2);

    // R10 idle write takes effect
    wr(0, enc(0, 1, 0, 0, 8'hC3));
    run(0);
    chk("R10", "idle write payload", int'(got[0]), 'hC3);
    chk("R10", "idle write single", n_got, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule